// File: doc/BRIEF.md
# Playout Pointer Controller for a TDM Jitter Buffer

This block steers one channel of a circular playout buffer that sits in external memory. Bytes taken from received voice packets arrive on a write port, and the block returns the memory address and a write strobe for each one. A frame tick on the read side asks for one byte per TDM frame, and the block returns the read address or a fill indication. The block holds the write and read pointers, places the write pointer a programmable number of frames ahead of the read pointer when the first packet arrives, and watches the fill level for slips.

When the buffer runs dry or would overflow, the block relocates the read pointer to a fixed target fill level. Each slip direction has its own choice between an edge target and a middle target. Software can queue a one-shot signed shift of the write pointer, which is applied at the next packet start and then acknowledged by the hardware. The block can also drop bytes that equal a silence pattern, and it forwards single-cycle clock-recovery reference pulses for timing packets.

All address, strobe, slip and pulse outputs are combinational from the current state and inputs. Pointer state changes on the rising clock edge. The fill level is (write pointer − read pointer) mod DEPTH, with DEPTH = 2^ADDR_W.

Top module: `jb_playout_ctrl`

## Requirements
- R1: `init_o` is 0 after reset and after an `open_i` cycle. It becomes 1 in the cycle after the first accepted byte flagged `pkt_start_i`. Bytes that arrive before that start byte are ignored: no strobe and no pointer move.
- R2: The first packet's start byte is written at address (rd + min(`lead_i`, `max_pdv_i`)) mod DEPTH. Each further accepted byte goes to the next address, and the write pointer wraps modulo DEPTH.
- R3: On a frame tick with `init_o`=1 and a nonzero level, `rd_en_o`=1 with `rd_addr_o`=rd, and rd advances by 1. With a zero level it is an underrun: `fill_o`=1 and rd becomes wr − Tu. Tu is 1 when `slip_mode_i[1]`=0 (edge) and DEPTH/2 when it is 1 (middle). A tick before init gives `fill_o`=1 and moves nothing.
- R4: A byte accepted while its target level (address − rd) equals DEPTH−1 is an overrun. The byte is still handled, and rd becomes (new wr) − To. To is DEPTH−1 when `slip_mode_i[0]`=0 (edge) and DEPTH/2 when it is 1 (middle). This relocation takes precedence over a coincident tick advance.
- R5: `slip_under_o` and `slip_over_o` pulse high in the slip cycle only when `slip_rep_en_i`=1, and they stay 0 when it is 0.
- R6: An `adj_req_i` cycle sets `adj_pend_o`. It clears in the cycle after the adjustment is applied. A request in the same cycle as an apply keeps the flag set.
- R7: While the flag is pending and `init_o`=1, a packet start byte is written at wr + A, where A is `adj_val_i` read as two's complement and clamped to ±(DEPTH−1), taken mod DEPTH. An A of 0 leaves the delay unchanged.
- R8: `dly_min_o` and `dly_max_o` track the lowest and highest level seen on non-underrun ticks. They hold DEPTH−1 and 0 after reset or open. In an apply cycle both are shifted by A mod DEPTH instead of sampled.
- R9: With `sil_en_i`=1, a byte equal to `sil_pat_i` produces no `wr_en_o`, but the write pointer still advances past it.
- R10: `cr_ref_a_o` and `cr_ref_b_o` are high exactly in the cycles of an accepted start byte with `timing_ref_i`=1 and their own enable set.
- R11: `open_i` sets both pointers to 0 and clears the init and pending flags. It masks that cycle's bytes, ticks and adjust request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| open_i | input | 1 | Channel open pulse |
| lead_i | input | ADDR_W | Initial lead in frames |
| max_pdv_i | input | ADDR_W | Upper bound for the lead |
| slip_mode_i | input | 2 | [1] underrun target, [0] overrun target; 0 edge, 1 middle |
| slip_rep_en_i | input | 1 | Slip reporting enable |
| adj_req_i | input | 1 | Delay adjustment request pulse |
| adj_val_i | input | ADJ_W | Signed adjustment in frames |
| sil_en_i | input | 1 | Silence suppression enable |
| sil_pat_i | input | DATA_W | Silence pattern |
| cr_en_a_i | input | 1 | Reference pulse A enable |
| cr_en_b_i | input | 1 | Reference pulse B enable |
| byte_valid_i | input | 1 | Packet byte valid |
| pkt_start_i | input | 1 | Byte is the first of a packet |
| timing_ref_i | input | 1 | Packet is a timing reference |
| byte_i | input | DATA_W | Packet byte |
| wr_en_o | output | 1 | Memory write strobe |
| wr_addr_o | output | ADDR_W | Memory write address |
| wr_data_o | output | DATA_W | Memory write data |
| frame_tick_i | input | 1 | One TDM frame read request |
| rd_en_o | output | 1 | Memory read strobe |
| rd_addr_o | output | ADDR_W | Memory read address |
| fill_o | output | 1 | Play fill instead of buffer data |
| slip_under_o | output | 1 | Underrun slip report |
| slip_over_o | output | 1 | Overrun slip report |
| cr_ref_a_o | output | 1 | Clock-recovery reference pulse A |
| cr_ref_b_o | output | 1 | Clock-recovery reference pulse B |
| init_o | output | 1 | Channel initialised by hardware |
| adj_pend_o | output | 1 | Adjustment pending |
| dly_min_o | output | ADDR_W | Lowest observed level |
| dly_max_o | output | ADDR_W | Highest observed level |

## Verification
A corrupted write or read pointer shows at once: the next strobe carries `wr_addr_o` or `rd_addr_o` at the wrong value. A wrong level surfaces on the next tick or byte, as a slip that should not occur, or one that is missing, on `fill_o`, `slip_under_o` or `slip_over_o`. A wrong slip target or adjustment appears one cycle later in the addresses, and later still in `dly_min_o`/`dly_max_o`. The bench therefore compares every output against its model in every cycle, across dry, flooded, adjusted, suppressed and reopened phases.

// File: rtl/jb_pkg.sv
package jb_pkg;
  typedef enum logic {
    TGT_EDGE = 1'b0,
    TGT_MID  = 1'b1
  } slip_tgt_e;
endpackage

// File: rtl/jb_wr_path.sv
module jb_wr_path #(
  parameter int ADDR_W = 5,
  parameter int ADJ_W  = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              open_i,
  input  logic              valid_i,
  input  logic              pkt_start_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              init_i,
  input  logic              pend_i,
  input  logic [ADDR_W-1:0] rd_i,
  input  logic [ADDR_W-1:0] lead_i,
  input  logic [ADDR_W-1:0] max_pdv_i,
  input  logic [ADJ_W-1:0]  adj_val_i,
  input  logic              sil_en_i,
  input  logic [DATA_W-1:0] sil_pat_i,
  output logic [ADDR_W-1:0] wr_q_o,
  output logic [ADDR_W-1:0] wr_next_o,
  output logic              act_o,
  output logic              first_o,
  output logic              apply_o,
  output logic              overrun_o,
  output logic [ADDR_W-1:0] adj_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o
);
  localparam logic [ADDR_W-1:0] FULL_LVL = '1;
  localparam logic [ADDR_W-1:0] ONE      = {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic signed [ADJ_W-1:0] ADJ_MAX = ADJ_W'((1 << ADDR_W) - 1);
  localparam logic signed [ADJ_W-1:0] ADJ_NEG = -ADJ_MAX;

  logic [ADDR_W-1:0] wr_q, lead_eff, base;

  always_comb begin
    lead_eff = (lead_i > max_pdv_i) ? max_pdv_i : lead_i;
    // clamp to +-(DEPTH-1), then reduce mod DEPTH
    if ($signed(adj_val_i) > ADJ_MAX)      adj_o = FULL_LVL;
    else if ($signed(adj_val_i) < ADJ_NEG) adj_o = ONE;
    else                                   adj_o = adj_val_i[ADDR_W-1:0];
    first_o = valid_i & pkt_start_i & ~init_i;
    apply_o = valid_i & pkt_start_i & init_i & pend_i;
    act_o   = valid_i & (init_i | pkt_start_i);
    if (first_o)      base = rd_i + lead_eff;
    else if (apply_o) base = wr_q + adj_o;
    else              base = wr_q;
    overrun_o = act_o & ((base - rd_i) == FULL_LVL);
    wr_en_o   = act_o & ~(sil_en_i & (byte_i == sil_pat_i));
    wr_addr_o = base;
    if (open_i)     wr_next_o = '0;
    else if (act_o) wr_next_o = base + ONE;
    else            wr_next_o = wr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_q <= '0;
    else         wr_q <= wr_next_o;
  end

  assign wr_q_o = wr_q;

  AST_FIRST_LEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_o |=> wr_q == $past(rd_i) + $past(lead_eff) + ONE); // R2

endmodule

// File: rtl/jb_rd_path.sv
module jb_rd_path
  import jb_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              open_i,
  input  logic              tick_i,
  input  logic              init_i,
  input  logic [ADDR_W-1:0] wr_q_i,
  input  logic [ADDR_W-1:0] wr_next_i,
  input  logic              wr_act_i,
  input  logic              overrun_i,
  input  logic [1:0]        slip_mode_i,
  output logic [ADDR_W-1:0] rd_q_o,
  output logic [ADDR_W-1:0] lvl_o,
  output logic              rd_en_o,
  output logic              underrun_o
);
  localparam logic [ADDR_W-1:0] FULL_LVL = '1;
  localparam logic [ADDR_W-1:0] HALF_LVL = {1'b1, {(ADDR_W-1){1'b0}}};
  localparam logic [ADDR_W-1:0] ONE      = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] rd_q, rd_next, tgt_u, tgt_o;
  slip_tgt_e         mode_u, mode_o;

  always_comb begin
    mode_u     = slip_tgt_e'(slip_mode_i[1]);
    mode_o     = slip_tgt_e'(slip_mode_i[0]);
    tgt_u      = (mode_u == TGT_MID) ? HALF_LVL : ONE;
    tgt_o      = (mode_o == TGT_MID) ? HALF_LVL : FULL_LVL;
    lvl_o      = wr_q_i - rd_q;
    rd_en_o    = tick_i & init_i & (lvl_o != '0);
    underrun_o = tick_i & init_i & (lvl_o == '0);
    if (open_i)          rd_next = '0;
    else if (overrun_i)  rd_next = wr_next_i - tgt_o;
    else if (underrun_o) rd_next = wr_q_i - tgt_u;
    else if (rd_en_o)    rd_next = rd_q + ONE;
    else                 rd_next = rd_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= rd_next;
  end

  assign rd_q_o = rd_q;

  AST_UNDER_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o && !wr_act_i |=> (wr_q_i - rd_q) == $past(tgt_u)); // R3
  AST_OVER_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_i |=> (wr_q_i - rd_q) == $past(tgt_o)); // R4
  AST_NO_READ_BEFORE_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_i && !open_i |=> rd_q == $past(rd_q)); // R3

endmodule

// File: rtl/jb_dly_track.sv
module jb_dly_track #(
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              open_i,
  input  logic              sample_i,
  input  logic [ADDR_W-1:0] lvl_i,
  input  logic              apply_i,
  input  logic [ADDR_W-1:0] adj_i,
  output logic [ADDR_W-1:0] min_o,
  output logic [ADDR_W-1:0] max_o
);
  logic [ADDR_W-1:0] min_q, max_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      min_q <= '1;
      max_q <= '0;
    end else if (open_i) begin
      min_q <= '1;
      max_q <= '0;
    end else if (apply_i) begin
      min_q <= min_q + adj_i;
      max_q <= max_q + adj_i;
    end else if (sample_i) begin
      if (lvl_i < min_q) min_q <= lvl_i;
      if (lvl_i > max_q) max_q <= lvl_i;
    end
  end

  assign min_o = min_q;
  assign max_o = max_q;

  AST_SHIFT_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply_i && !open_i |=> min_q == $past(min_q) + $past(adj_i)); // R8

endmodule

// File: rtl/jb_playout_ctrl.sv
module jb_playout_ctrl #(
  parameter int ADDR_W = 5,
  parameter int ADJ_W  = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              open_i,
  input  logic [ADDR_W-1:0] lead_i,
  input  logic [ADDR_W-1:0] max_pdv_i,
  input  logic [1:0]        slip_mode_i,
  input  logic              slip_rep_en_i,
  input  logic              adj_req_i,
  input  logic [ADJ_W-1:0]  adj_val_i,
  input  logic              sil_en_i,
  input  logic [DATA_W-1:0] sil_pat_i,
  input  logic              cr_en_a_i,
  input  logic              cr_en_b_i,
  input  logic              byte_valid_i,
  input  logic              pkt_start_i,
  input  logic              timing_ref_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              frame_tick_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              fill_o,
  output logic              slip_under_o,
  output logic              slip_over_o,
  output logic              cr_ref_a_o,
  output logic              cr_ref_b_o,
  output logic              init_o,
  output logic              adj_pend_o,
  output logic [ADDR_W-1:0] dly_min_o,
  output logic [ADDR_W-1:0] dly_max_o
);
  logic              init_q, pend_q;
  logic              valid_w, tick_w, ref_w;
  logic [ADDR_W-1:0] wr_q, wr_next, rd_q, lvl, adj_w;
  logic              wr_act, first_pkt, apply, overrun, underrun, rd_en;

  assign valid_w = byte_valid_i & ~open_i;
  assign tick_w  = frame_tick_i & ~open_i;

  jb_wr_path #(.ADDR_W(ADDR_W), .ADJ_W(ADJ_W), .DATA_W(DATA_W)) i_wr (
    .clk_i, .rst_ni, .open_i,
    .valid_i(valid_w), .pkt_start_i, .byte_i,
    .init_i(init_q), .pend_i(pend_q), .rd_i(rd_q),
    .lead_i, .max_pdv_i, .adj_val_i, .sil_en_i, .sil_pat_i,
    .wr_q_o(wr_q), .wr_next_o(wr_next), .act_o(wr_act),
    .first_o(first_pkt), .apply_o(apply), .overrun_o(overrun),
    .adj_o(adj_w), .wr_en_o, .wr_addr_o
  );

  jb_rd_path #(.ADDR_W(ADDR_W)) i_rd (
    .clk_i, .rst_ni, .open_i,
    .tick_i(tick_w), .init_i(init_q),
    .wr_q_i(wr_q), .wr_next_i(wr_next), .wr_act_i(wr_act),
    .overrun_i(overrun), .slip_mode_i,
    .rd_q_o(rd_q), .lvl_o(lvl), .rd_en_o(rd_en), .underrun_o(underrun)
  );

  jb_dly_track #(.ADDR_W(ADDR_W)) i_dly (
    .clk_i, .rst_ni, .open_i,
    .sample_i(rd_en), .lvl_i(lvl), .apply_i(apply), .adj_i(adj_w),
    .min_o(dly_min_o), .max_o(dly_max_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (open_i)         init_q <= 1'b0;
      else if (first_pkt) init_q <= 1'b1;
      if (open_i)         pend_q <= 1'b0;
      else if (adj_req_i) pend_q <= 1'b1;
      else if (apply)     pend_q <= 1'b0;
    end
  end

  assign ref_w        = valid_w & pkt_start_i & timing_ref_i;
  assign wr_data_o    = byte_i;
  assign rd_en_o      = rd_en;
  assign rd_addr_o    = rd_q;
  assign fill_o       = tick_w & ~rd_en;
  assign slip_under_o = underrun & slip_rep_en_i;
  assign slip_over_o  = overrun & slip_rep_en_i;
  assign cr_ref_a_o   = ref_w & cr_en_a_i;
  assign cr_ref_b_o   = ref_w & cr_en_b_i;
  assign init_o       = init_q;
  assign adj_pend_o   = pend_q;

  AST_INIT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_q && !open_i |=> init_q); // R1
  AST_PEND_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply && !adj_req_i |=> !pend_q); // R6
  AST_OPEN_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_i |=> !init_q && !pend_q && rd_q == '0 && wr_q == '0); // R11

endmodule

// File: tb/test_jb_playout_ctrl.sv
module test_jb_playout_ctrl;
  localparam int CLK_P = 10;
  localparam int AW = 5;
  localparam int D = 1 << AW;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic op = 0, areq = 0, rep = 1, sil = 0, ena = 0, enb = 0;
  logic bv = 0, ps = 0, tr = 0, ft = 0;
  logic [AW-1:0] lead_v = 4, pdv_v = 8;
  logic [1:0] mode_v = 2'b10;
  logic [11:0] adj_v = 0;
  logic [7:0] pat_v = 8'h55, byte_v = 0;
  logic [15:0] lf = 16'hACE1;

  logic wr_en_o, rd_en_o, fill_o, su_o, so_o, cra_o, crb_o, init_o, pend_o;
  logic [AW-1:0] wr_addr_o, rd_addr_o, min_o, max_o;
  logic [7:0] wr_data_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  int m_wr, m_rd, m_min, m_max, n_wr, n_rd, n_min, n_max;
  bit m_init, m_pend, n_init, n_pend;

  always #(CLK_P/2) clk_i = ~clk_i;

  jb_playout_ctrl #(.ADDR_W(AW), .ADJ_W(12), .DATA_W(8)) i_jb_playout_ctrl (
    .clk_i, .rst_ni, .open_i(op), .lead_i(lead_v), .max_pdv_i(pdv_v),
    .slip_mode_i(mode_v), .slip_rep_en_i(rep), .adj_req_i(areq), .adj_val_i(adj_v),
    .sil_en_i(sil), .sil_pat_i(pat_v), .cr_en_a_i(ena), .cr_en_b_i(enb),
    .byte_valid_i(bv), .pkt_start_i(ps), .timing_ref_i(tr), .byte_i(byte_v),
    .wr_en_o, .wr_addr_o, .wr_data_o, .frame_tick_i(ft),
    .rd_en_o, .rd_addr_o, .fill_o, .slip_under_o(su_o), .slip_over_o(so_o),
    .cr_ref_a_o(cra_o), .cr_ref_b_o(crb_o), .init_o, .adj_pend_o(pend_o),
    .dly_min_o(min_o), .dly_max_o(max_o)
  );

  function automatic int md(input int x);
    return ((x % D) + D) % D;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_eval();
    bit vw, tk, first, apply, wact, ov, un, rde, sup;
    int lead, adj, base, lvl, tu, to;
    vw = bv && !op;
    tk = ft && !op;
    first = vw && ps && !m_init;
    apply = vw && ps && m_init && m_pend;
    wact = vw && (m_init || ps);
    lead = (lead_v > pdv_v) ? int'(pdv_v) : int'(lead_v);
    adj = int'($signed(adj_v));
    if (adj > D-1) adj = D-1;
    if (adj < -(D-1)) adj = -(D-1);
    base = first ? md(m_rd + lead) : apply ? md(m_wr + adj) : m_wr;
    ov = wact && (md(base - m_rd) == D-1);
    sup = sil && (byte_v == pat_v);
    lvl = md(m_wr - m_rd);
    rde = tk && m_init && lvl != 0;
    un = tk && m_init && lvl == 0;
    tu = mode_v[1] ? D/2 : 1;
    to = mode_v[0] ? D/2 : D-1;
    // combinational outputs
    chk("R9 wr_en", int'(wr_en_o), int'(wact && !sup));
    if (wact) chk("R2 R7 wr_addr", int'(wr_addr_o), base);
    chk("R2 wr_data", int'(wr_data_o), int'(byte_v));
    chk("R3 rd_en", int'(rd_en_o), int'(rde));
    chk("R3 R4 R11 rd_addr", int'(rd_addr_o), m_rd);
    chk("R3 fill", int'(fill_o), int'(tk && !rde));
    chk("R5 slip_under", int'(su_o), int'(un && rep));
    chk("R5 slip_over", int'(so_o), int'(ov && rep));
    chk("R10 cr_a", int'(cra_o), int'(vw && ps && tr && ena));
    chk("R10 cr_b", int'(crb_o), int'(vw && ps && tr && enb));
    chk("R1 R11 init", int'(init_o), int'(m_init));
    chk("R6 pending", int'(pend_o), int'(m_pend));
    chk("R8 min", int'(min_o), m_min);
    chk("R8 max", int'(max_o), m_max);
    // next state
    n_wr = op ? 0 : wact ? md(base + 1) : m_wr;
    n_rd = op ? 0 : ov ? md(n_wr - to) : un ? md(m_wr - tu) : rde ? md(m_rd + 1) : m_rd;
    n_init = op ? 0 : first ? 1 : m_init;
    n_pend = op ? 0 : areq ? 1 : apply ? 0 : m_pend;
    if (op) begin n_min = D-1; n_max = 0; end
    else if (apply) begin n_min = md(m_min + adj); n_max = md(m_max + adj); end
    else begin
      n_min = (rde && lvl < m_min) ? lvl : m_min;
      n_max = (rde && lvl > m_max) ? lvl : m_max;
    end
  endtask

  task automatic step();
    #1;
    model_eval();
    @(posedge clk_i);
    m_wr = n_wr; m_rd = n_rd; m_min = n_min; m_max = n_max;
    m_init = n_init; m_pend = n_pend;
    @(negedge clk_i);
    op = 0; areq = 0; bv = 0; ps = 0; tr = 0; ft = 0;
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  task automatic pkt(input int n, input bit tref);
    for (int i = 0; i < n; i++) begin
      bv = 1; ps = (i == 0); tr = tref && (i == 0); byte_v = lf[7:0];
      step();
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin ft = 1; step(); end
  endtask

  task automatic mix(input int n, input int wr_thr, input int tk_thr);
    for (int i = 0; i < n; i++) begin
      bv = (int'(lf[3:0]) < wr_thr);
      ps = bv && (lf[6:4] == 3'd0);
      tr = lf[8];
      ft = (int'(lf[12:9]) < tk_thr);
      areq = (lf[15:10] == 6'd5);
      byte_v = lf[7:0];
      step();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    m_wr = 0; m_rd = 0; m_min = D-1; m_max = 0; m_init = 0; m_pend = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    #1;
    chk("R1 reset init", int'(init_o), 0);
    chk("R8 reset min", int'(min_o), D-1);
    @(negedge clk_i);
    // stray byte and tick before init
    bv = 1; byte_v = 8'h11; step();
    ticks(2);
    // first packet with reference A
    ena = 1;
    pkt(6, 1);
    ticks(14);             // drains and underruns to middle
    pkt(3, 0);
    mode_v = 2'b00;        // underrun to edge
    ticks(8);
    // adjustments: +3, -2, clamped large, zero
    adj_v = 12'd3;   areq = 1; step(); pkt(4, 0);
    adj_v = 12'hFFE; areq = 1; step(); ticks(2); pkt(4, 0);
    adj_v = 12'd100; areq = 1; step(); pkt(2, 0);
    adj_v = 12'd0;   areq = 1; step(); pkt(2, 0);
    // request and apply in the same cycle
    adj_v = 12'd2; areq = 1; step();
    bv = 1; ps = 1; areq = 1; step();
    pkt(2, 0);
    ticks(6);
    // overrun: edge then middle
    mode_v = 2'b10; pkt(40, 0);
    mode_v = 2'b01; pkt(40, 0);
    bv = 1; ft = 1; step();    // overrun coincident with tick
    // reports off
    rep = 0; ticks(40); pkt(40, 0); rep = 1;
    // silence suppression
    sil = 1;
    for (int i = 0; i < 8; i++) begin
      bv = 1; ps = (i == 0); byte_v = (i % 2 == 0) ? 8'h55 : 8'(i);
      step();
    end
    sil = 0;
    ticks(4);
    // reference B only
    ena = 0; enb = 1; pkt(3, 1); ena = 1;
    // open mid-stream with everything else asserted, then clamped lead
    op = 1; bv = 1; ps = 1; ft = 1; areq = 1; step();
    lead_v = 20; pdv_v = 8;
    ticks(2);
    pkt(5, 1);
    ticks(3);
    // randomised traffic: write heavy, read heavy, balanced
    mode_v = 2'b11; mix(300, 12, 4);
    mode_v = 2'b00; mix(300, 4, 12);
    sil = 1; mode_v = 2'b10; mix(300, 8, 8);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule